// File: doc/BRIEF.md
# Parallel Port Mode and Service Control Register

This block is the 8-bit extended control and status register of a byte-FIFO parallel port. Host software uses it to choose the port's operating mode. It also enables DMA, arms the error interrupt and arms the service interrupt. When read, it reports whether the port FIFO is empty or full. The block keeps an occupancy counter for that FIFO, driven by push and pop strobes from the datapath. From the counter, the mode, the transfer direction, the active-low fault input and the DMA terminal count, it produces a single-cycle interrupt pulse and a DMA request with its output enable.

The mode field is guarded. From the two basic modes (standard output and bidirectional without FIFO) software may move to any mode. From any other mode it may only return to one of the two basic modes. The service bit is written low by software to arm the service interrupt. The hardware sets it high again in the cycle the interrupt fires, so a condition that stays true cannot fire a second time until software clears the bit again.

Top module: `pport_ecr`

## Requirements
- R1: After reset, `rd_data` reads 8'h95: mode 100, bit 4 = 1, bit 3 = 0, bit 2 = 1, bit 1 = 0, bit 0 = 1. `irq` and `dma_req_oe` are low.
- R2: Bit 0 of `rd_data` is 1 when the FIFO count is zero. It is forced to 1 in every mode other than 010, 011 and 110.
- R3: Bit 1 of `rd_data` is 1 when the FIFO count equals DEPTH. It is forced to 0 in every mode other than 010, 011 and 110.
- R4: When the current mode (bits 7:5) is 000 or 001, a write sets the mode to any value. From any other mode, only writes of 000 or 001 change it, and other values leave the mode unchanged.
- R5: Writes store bits 4 (error-interrupt disable), 3 (DMA enable) and 2 (service) directly. Bits 1:0 ignore writes.
- R6: `dir_eff` is 0 in modes 000 and 010. In every other mode it equals `dir_ctl`.
- R7: The service interrupt only acts in modes 010, 011 and 110, with bit 2 = 0 and bit 3 = 0. With `dir_eff` = 0, it fires when DEPTH minus the count is at least THRESH. Firing means one edge sets bit 2 to 1 and raises `irq` for exactly one cycle.
- R8: With bit 3 = 0 and `dir_eff` = 1, the service interrupt fires when the count is at least THRESH.
- R9: With bit 3 = 1, the service interrupt fires only when `dma_tc` is high. The FIFO thresholds have no effect.
- R10: `dma_req_oe` equals bit 3. `dma_req` is high only when bit 3 = 1, bit 2 = 0, the mode is 010, 011 or 110, and the FIFO can move data in the current direction (not full when forward, not empty when reverse).
- R11: In mode 011 with bit 4 = 0, `fault_n` falling low gives one `irq` pulse, which does not repeat while `fault_n` stays low. In other modes a low `fault_n` gives no interrupt.
- R12: The count stays between 0 and DEPTH. It ignores a push when full and a pop when empty. A push and a pop in the same cycle leave it unchanged.
- R13: After the service interrupt fires, `irq` stays low while the condition persists, until software writes bit 2 to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| dir_ctl | input | 1 | Direction control from the port control register (1 = reverse) |
| dir_eff | output | 1 | Effective transfer direction after mode forcing |
| fifo_push | input | 1 | FIFO byte written |
| fifo_pop | input | 1 | FIFO byte read |
| fifo_level | output | CW | FIFO occupancy count |
| fault_n | input | 1 | Active-low peripheral fault |
| dma_tc | input | 1 | DMA terminal count |
| irq | output | 1 | Single-cycle interrupt pulse |
| dma_req | output | 1 | DMA request |
| dma_req_oe | output | 1 | Output enable of the DMA request pin |

## Verification
The bench builds the block with its default parameters: DEPTH 16 and THRESH 8. With these, filling and draining the FIFO takes only a few dozen cycles, so the full and empty boundaries and both saturation cases are reached directly. With THRESH at half the depth, the forward and reverse service conditions both switch between counts 7, 8 and 9. The bench uses those counts to land one cycle on each side of the firing edge.

// File: rtl/pport_ecr.sv
module pport_ecr #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          dir_ctl,
  output logic          dir_eff,
  input  logic          fifo_push,
  input  logic          fifo_pop,
  output logic [CW-1:0] fifo_level,
  input  logic          fault_n,
  input  logic          dma_tc,
  output logic          irq,
  output logic          dma_req,
  output logic          dma_req_oe
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] THR_C  = CW'(THRESH);

  logic [2:0]    mode;
  logic          err_dis, dma_en, svc, irq_q, err_q;
  logic [CW-1:0] cnt;

  wire fifo_mode = (mode == 3'b010) || (mode == 3'b011) || (mode == 3'b110);
  wire basic_now = (mode[2:1] == 2'b00);
  wire basic_wr  = (wr_data[7:6] == 2'b00);
  wire is_full   = (cnt == FULL_C);
  wire is_empty  = (cnt == '0);
  wire do_push   = fifo_push && !is_full;
  wire do_pop    = fifo_pop && !is_empty;

  assign dir_eff = (mode == 3'b000 || mode == 3'b010) ? 1'b0 : dir_ctl;

  wire [CW-1:0] free_cnt = FULL_C - cnt;
  wire lvl_cond = dir_eff ? (cnt >= THR_C) : (free_cnt >= THR_C);
  wire svc_cond = dma_en ? dma_tc : lvl_cond;
  wire svc_fire = fifo_mode && !svc && svc_cond;
  wire err_cond = (mode == 3'b011) && !err_dis && !fault_n;
  wire err_fire = err_cond && !err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= 3'b100;
      err_dis <= 1'b1;
      dma_en  <= 1'b0;
      svc     <= 1'b1;
    end else begin
      if (wr_en) begin
        if (basic_now || basic_wr) mode <= wr_data[7:5];
        err_dis <= wr_data[4];
        dma_en  <= wr_data[3];
      end
      if (svc_fire)   svc <= 1'b1;
      else if (wr_en) svc <= wr_data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (do_push && !do_pop) begin
      cnt <= cnt + 1'b1;
    end else if (do_pop && !do_push) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= svc_fire || err_fire;
      err_q <= err_cond;
    end
  end

  wire empty_flag = fifo_mode ? is_empty : 1'b1;
  wire full_flag  = fifo_mode ? is_full  : 1'b0;

  assign rd_data    = {mode, err_dis, dma_en, svc, full_flag, empty_flag};
  assign fifo_level = cnt;
  assign irq        = irq_q;
  assign dma_req_oe = dma_en;
  assign dma_req    = dma_en && !svc && fifo_mode && (dir_eff ? !is_empty : !is_full);

  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && fifo_push && !fifo_pop) |=> (fifo_level == FULL_C));

  // R4
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !basic_now && !basic_wr) |=> $stable(rd_data[7:5]));

  // R7
  svc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> (rd_data[2] && irq));

  // R10
  dma_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_req_oe && !rd_data[2]));

  // R2
  empty_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> rd_data[0]);

endmodule

// File: tb/test_pport_ecr.sv
module test_pport_ecr;
  localparam int DEPTH  = 16;
  localparam int THRESH = 8;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic dir_ctl = 1'b0;
  logic dir_eff;
  logic fifo_push = 1'b0, fifo_pop = 1'b0;
  logic [CW-1:0] fifo_level;
  logic fault_n = 1'b1, dma_tc = 1'b0;
  logic irq, dma_req, dma_req_oe;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pport_ecr #(.DEPTH(DEPTH), .THRESH(THRESH)) i_pport_ecr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dir_ctl(dir_ctl), .dir_eff(dir_eff), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_level(fifo_level), .fault_n(fault_n), .dma_tc(dma_tc), .irq(irq),
    .dma_req(dma_req), .dma_req_oe(dma_req_oe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_mode(logic [2:0] m, logic [4:0] low);
    wr({3'b000, low});
    wr({m, low});
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin fifo_push = 1'b1; tick(); end
    fifo_push = 1'b0;
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin fifo_pop = 1'b1; tick(); end
    fifo_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h95);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req_oe", dma_req_oe, 0);
  endtask

  task automatic t_mode_rules();
    wr(8'h00);
    chk("R4 100->000", rd_data, 8'h01);
    wr(8'h74);
    chk("R4 000->011", rd_data, 8'h75);
    wr(8'h94);
    chk("R4 011 locked vs 100", rd_data, 8'h75);
    wr(8'h34);
    chk("R4 011->001", rd_data, 8'h35);
    wr(8'hC4);
    chk("R4 001->110", rd_data, 8'hC5);
    wr(8'h4C);
    chk("R4 110 locked vs 010 / R5 bit3", rd_data, 8'hCD);
    wr(8'h04);
    chk("R4 110->000 / R5", rd_data, 8'h05);
    wr(8'h07);
    chk("R5 bits1:0 ignore writes", rd_data, 8'h05);
  endtask

  task automatic t_direction();
    dir_ctl = 1'b1;
    set_mode(3'b000, 5'b00100);
    chk("R6 mode000 forced fwd", dir_eff, 0);
    set_mode(3'b001, 5'b10100);
    chk("R6 mode001 follows", dir_eff, 1);
    set_mode(3'b010, 5'b10100);
    chk("R6 mode010 forced fwd", dir_eff, 0);
    set_mode(3'b011, 5'b10100);
    chk("R6 mode011 follows", dir_eff, 1);
    dir_ctl = 1'b0;
  endtask

  task automatic t_fifo();
    set_mode(3'b010, 5'b10100);
    push_n(DEPTH);
    chk("R3 full level", fifo_level, DEPTH);
    chk("R3 full flag", rd_data, 8'h56);
    push_n(1);
    chk("R12 push when full", fifo_level, DEPTH);
    pop_n(DEPTH);
    chk("R2 empty flag", rd_data, 8'h55);
    pop_n(1);
    chk("R12 pop when empty", fifo_level, 0);
    push_n(3);
    fifo_push = 1'b1; fifo_pop = 1'b1; tick();
    fifo_push = 1'b0; fifo_pop = 1'b0;
    chk("R12 push+pop", fifo_level, 3);
    wr(8'h14);
    chk("R2 R3 forced in mode000", rd_data, 8'h15);
    wr(8'h54);
    chk("R2 real flag in 010", rd_data, 8'h54);
    pop_n(3);
  endtask

  task automatic t_svc_fwd();
    set_mode(3'b010, 5'b10100);
    push_n(THRESH + 1);
    wr(8'h50);
    chk("R7 svc cleared", rd_data[2], 0);
    tick();
    chk("R7 no fire free<thresh", irq, 0);
    pop_n(1);
    chk("R7 not yet", irq, 0);
    tick();
    chk("R7 fire irq", irq, 1);
    chk("R7 svc set", rd_data, 8'h54);
    tick();
    chk("R13 pulse ends", irq, 0);
    tick();
    chk("R13 no retrigger", irq, 0);
  endtask

  task automatic t_svc_rev();
    dir_ctl = 1'b1;
    set_mode(3'b011, 5'b10100);
    pop_n(1);
    wr(8'h70);
    tick();
    chk("R8 no fire below thresh", irq, 0);
    push_n(1);
    chk("R8 not yet", irq, 0);
    tick();
    chk("R8 fire reverse", irq, 1);
    chk("R8 svc set", rd_data[2], 1);
  endtask

  task automatic t_dma();
    wr(8'h78);
    chk("R10 oe", dma_req_oe, 1);
    chk("R10 req", dma_req, 1);
    tick();
    chk("R9 threshold ignored", irq, 0);
    dma_tc = 1'b1; tick(); dma_tc = 1'b0;
    chk("R9 tc fires", irq, 1);
    chk("R9 svc set", rd_data[2], 1);
    chk("R10 req drops", dma_req, 0);
    tick();
    chk("R13 tc pulse ends", irq, 0);
    wr(8'h70);
    chk("R10 oe off", dma_req_oe, 0);
    chk("R10 req off", dma_req, 0);
    wr(8'h74);
    dir_ctl = 1'b0;
  endtask

  task automatic t_err();
    wr(8'h64);
    fault_n = 1'b0; tick();
    chk("R11 err pulse", irq, 1);
    tick();
    chk("R11 no repeat", irq, 0);
    tick();
    chk("R11 still none", irq, 0);
    fault_n = 1'b1;
    set_mode(3'b010, 5'b00100);
    fault_n = 1'b0; tick();
    chk("R11 no err in 010", irq, 0);
    tick();
    chk("R11 no err in 010 later", irq, 0);
    fault_n = 1'b1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mode_rules();
    t_direction();
    t_fifo();
    t_svc_fwd();
    t_svc_rev();
    t_dma();
    t_err();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule